// File: doc/BRIEF.md
# Pipeline General-Purpose Register Bank with Write-Through Reads

This block holds the architectural integer registers of a five-stage in-order pipeline. The decode stage reads two source operands at once through two combinational read ports. The write-back stage stores results through one write port on the rising clock edge. Only instructions that produce a register result raise the write enable. Stores, branches and bubbles leave it low.

A read that names the register being written in the same cycle sees the incoming value, not the stored one. The effect matches a write early in the cycle followed by a read late in the cycle. It is built with a compare-and-select path in front of each read port, and the bank uses a single clock edge. With this path the pipeline needs one fewer interlock cycle between a producer and a dependent consumer.

Every pin is a plain level signal. The bank accepts a write in every cycle it is enabled and has no back-pressure, so it uses no valid/ready handshake.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, and a reset takes priority over a write in the same cycle.
- R2: When `wr_en` is 1, `wr_sel` equals `rd_sel_a` and `rd_sel_a` is nonzero, `rd_val_a` equals `wr_val` in that same cycle.
- R3: When `wr_en` is 1, `wr_sel` equals `rd_sel_b` and `rd_sel_b` is nonzero, `rd_val_b` equals `wr_val` in that same cycle.
- R4: Register index 0 always reads as zero on both ports. A write to index 0 is discarded and is never forwarded.
- R5: A write with `wr_en` at 1 to a nonzero index is stored at the rising edge. Later reads of that index return the value until it is written again or reset.
- R6: While `wr_en` is 0, no register changes, whatever `wr_sel` and `wr_val` carry.
- R7: When the same register is written on consecutive cycles, each read returns the most recent write, and the last write is the one that is kept.
- R8: The two read ports work independently. Forwarding on one port has no effect on the other, and both ports may name the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable from write-back |
| wr_sel | input | 5 | Destination register index |
| wr_val | input | 32 | Result value to store |
| rd_sel_a | input | 5 | First source register index |
| rd_val_a | output | 32 | First source operand (combinational) |
| rd_sel_b | input | 5 | Second source register index |
| rd_val_b | output | 32 | Second source operand (combinational) |

## Verification
The hardest case to reach is a write and a read landing on the same register in the same cycle, which the forwarding path exists for. It has to be hit on each port alone, on both ports together, with the index at zero, and while that register is being rewritten on back-to-back cycles. Directed sequences set up each of these collisions. A long random phase then draws indices from a narrow range most of the time, so write and read addresses collide often. A behavioural model computes the expected operands before each edge and is compared with both ports every cycle.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned DEF_NREGS = 32;
  localparam int unsigned DEF_XLEN  = 32;
  localparam int unsigned NREAD     = 2;

  // source of a read port's value in the current cycle
  typedef enum logic [0:0] {
    SRC_ARRAY  = 1'b0,
    SRC_BYPASS = 1'b1
  } rd_src_e;
endpackage

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int unsigned NREGS = gpr_pkg::DEF_NREGS,
  parameter int unsigned XLEN  = gpr_pkg::DEF_XLEN,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_sel,
  input  logic [XLEN-1:0] wr_val,
  output logic [XLEN-1:0] regs_q [NREGS]
);
  // index 0 has no storage; it is tied to zero
  assign regs_q[0] = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_cell
    logic [XLEN-1:0] cell_q;
    logic            hit;
    assign hit = wr_en && (int'(wr_sel) == i);
    always_ff @(posedge clk) begin
      if (rst)      cell_q <= '0;
      else if (hit) cell_q <= wr_val;
    end
    assign regs_q[i] = cell_q;
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned NREGS = gpr_pkg::DEF_NREGS,
  parameter int unsigned XLEN  = gpr_pkg::DEF_XLEN,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic [XLEN-1:0] regs_q [NREGS],
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_sel,
  input  logic [XLEN-1:0] wr_val,
  input  logic [AW-1:0]   rd_sel,
  output logic [XLEN-1:0] rd_val
);
  import gpr_pkg::*;

  rd_src_e         src;
  logic [XLEN-1:0] arr_val;

  always_comb begin
    src = SRC_ARRAY;
    if (wr_en && (wr_sel == rd_sel) && (rd_sel != '0)) src = SRC_BYPASS;
  end

  always_comb begin
    arr_val = '0;
    if (int'(rd_sel) < NREGS) arr_val = regs_q[rd_sel];
  end

  assign rd_val = (src == SRC_BYPASS) ? wr_val : arr_val;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int unsigned NREGS = gpr_pkg::DEF_NREGS,
  parameter int unsigned XLEN  = gpr_pkg::DEF_XLEN,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_sel,
  input  logic [XLEN-1:0] wr_val,
  input  logic [AW-1:0]   rd_sel_a,
  output logic [XLEN-1:0] rd_val_a,
  input  logic [AW-1:0]   rd_sel_b,
  output logic [XLEN-1:0] rd_val_b
);
  import gpr_pkg::*;

  logic [XLEN-1:0] regs_q [NREGS];
  logic [AW-1:0]   sel_v  [NREAD];
  logic [XLEN-1:0] val_v  [NREAD];

  gpr_store #(.NREGS(NREGS), .XLEN(XLEN)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_val(wr_val), .regs_q(regs_q)
  );

  assign sel_v[0] = rd_sel_a;
  assign sel_v[1] = rd_sel_b;

  for (genvar p = 0; p < NREAD; p++) begin : g_port
    gpr_read_port #(.NREGS(NREGS), .XLEN(XLEN)) u_port (
      .regs_q(regs_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
      .rd_sel(sel_v[p]), .rd_val(val_v[p])
    );
  end

  assign rd_val_a = val_v[0];
  assign rd_val_b = val_v[1];

  // R2
  fwd_a_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == rd_sel_a && rd_sel_a != '0) |-> rd_val_a == wr_val);
  // R3
  fwd_b_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == rd_sel_b && rd_sel_b != '0) |-> rd_val_b == wr_val);
  // R4
  zero_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_a == '0) |-> rd_val_a == '0);
  // R4
  zero_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel_b == '0) |-> rd_val_b == '0);
  // R5
  stored_a_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && !$past(rst) && $past(wr_sel) != '0 && !wr_en &&
     rd_sel_a == $past(wr_sel)) |-> rd_val_a == $past(wr_val));
  // R6
  hold_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_en) && !$past(rst) && !wr_en && $stable(rd_sel_b))
    |-> $stable(rd_val_b));
endmodule

// File: tb/test_gpr_bank.sv
module test_gpr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_val = '0;
  logic [4:0]  rd_sel_a = '0;
  logic [31:0] rd_val_a;
  logic [4:0]  rd_sel_b = '0;
  logic [31:0] rd_val_b;

  int unsigned model [32];
  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk; // 250 MHz

  gpr_bank i_gpr_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
    .rd_sel_a(rd_sel_a), .rd_val_a(rd_val_a),
    .rd_sel_b(rd_sel_b), .rd_val_b(rd_val_b)
  );

  function automatic int unsigned expect_rd(input logic [4:0] s);
    if (s == 0) return 0;
    if (wr_en && wr_sel == s) return wr_val;
    return model[s];
  endfunction

  // one cycle: drive at negedge, compare mid-cycle, model update at posedge
  task automatic step(input bit r, input bit we, input int ws, input int unsigned wd,
                      input int sa, input int sb, input string tag, input bit chk = 1);
    int unsigned ea, eb;
    @(negedge clk);
    rst = r; wr_en = we; wr_sel = 5'(ws); wr_val = wd;
    rd_sel_a = 5'(sa); rd_sel_b = 5'(sb);
    #1;
    if (chk && !r) begin
      ea = expect_rd(rd_sel_a);
      eb = expect_rd(rd_sel_b);
      tests++;
      if (rd_val_a !== ea) begin
        fails++;
        $display("FAIL %s port a sel=%0d actual=%h expected=%h", tag, sa, rd_val_a, ea);
      end
      tests++;
      if (rd_val_b !== eb) begin
        fails++;
        $display("FAIL %s port b sel=%0d actual=%h expected=%h", tag, sb, rd_val_b, eb);
      end
    end
    @(posedge clk);
    if (r) foreach (model[i]) model[i] = 0;
    else if (we && ws != 0) model[ws] = wd;
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    step(1, 0, 0, 0, 0, 0, "R1", 0);
    step(1, 0, 0, 0, 0, 0, "R1", 0);
    // R1: every register zero after reset
    for (int r = 0; r < 32; r++) step(0, 0, 0, 0, r, 31 - r, "R1");
    // R2 R3 R8: same-cycle write and read on both ports
    step(0, 1, 5, 32'hA5A5_0001, 5, 5, "R2_R3");
    // R5: value kept
    step(0, 0, 0, 0, 5, 5, "R5");
    // R6: disabled write with live address/data
    step(0, 0, 5, 32'hDEAD_BEEF, 5, 6, "R6");
    step(0, 0, 0, 0, 5, 5, "R6");
    // R4: register 0 write, same cycle and after
    step(0, 1, 0, 32'hFFFF_FFFF, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R4");
    // R7: back-to-back writes to register 7
    step(0, 1, 7, 32'h0000_1111, 7, 7, "R7");
    step(0, 1, 7, 32'h0000_2222, 7, 3, "R7");
    step(0, 1, 7, 32'h0000_3333, 3, 7, "R7");
    step(0, 0, 0, 0, 7, 7, "R7");
    // R8: forwarding on port b only, port a on a different register
    step(0, 1, 9, 32'h1234_5678, 7, 9, "R8");
    step(0, 1, 7, 32'h8765_4321, 7, 9, "R8");
    step(0, 0, 0, 0, 7, 9, "R8");
    // R1: reset overrides a simultaneous write
    step(1, 1, 3, 32'hCAFE_F00D, 3, 3, "R1", 0);
    step(0, 0, 0, 0, 3, 7, "R1");
    step(0, 0, 0, 0, 9, 5, "R1");
    // random phase with narrow index range for frequent collisions
    for (int k = 0; k < 4000; k++) begin
      int w, a, b;
      w = ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 4);
      a = ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 4);
      b = ($urandom % 4 == 0) ? int'($urandom % 32) : int'($urandom % 4);
      step(($urandom % 500) == 0, ($urandom % 3) != 0, w, $urandom, a, b, "R2_R3_R5_R7");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule